// File: doc/BRIEF.md
# Sample Formatter and Test-Bus Multiplexer

This block sits between a digitizer and a three-pin digital output port. Each time the sample-clock enable is high it takes one signed two's-complement sample, quantizes it to a sign bit and a 1-bit or 2-bit magnitude, and maps those bits onto the three pins. The magnitude comes from comparing the sample's absolute value with thresholds that arrive as inputs.

A 2-bit test-select field can route diagnostic signals to the same pins in place of the sample bits. The diagnostic signals are divider terminal pulses, phase-detector pump pulses, a serial data-out bit, and calibration and clock-select flags. All three pins come from one register that loads only on the sample-clock enable. The pins therefore change together, and a change of format or test selection shows up only at the next enable.

Top module: `sample_fmt_testmux`

## Requirements
- R1: While `rst` is high the pins are driven to 3'b000, and they are 3'b000 in the cycle after `rst` falls.
- R2: `pins` changes only at a rising clock edge where `smp_en` is high. In every other cycle it holds its value.
- R3: The sign bit is 1 exactly when the sample is negative, that is when its MSB is 1.
- R4: The 2-bit magnitude is the number of thresholds (`thr_lo`, `thr_mid`, `thr_hi`) that the sample's absolute value strictly exceeds. With `mag1_sel`=0 and the sample selection active, the pins are {mag[1], mag[0], sign}, with sign on pin 0.
- R5: With `mag1_sel`=1 and the sample selection active, pin 2 is the sign and pin 1 is 1 exactly when the absolute value strictly exceeds `thr_mid`. Pin 0 is driven to 0.
- R6: `test_sel` selects what the pins carry. 2'b11 gives the formatted sample bits. 2'b10 gives {fb_tick, ref_tick, hs_flag}. 2'b01 gives {pump_up, pump_dn, sdo_bit}. 2'b00 gives {diag_clk, cal_done, clksel_flag}. Each list is pin 2 down to pin 0.
- R7: A change of `test_sel`, `mag1_sel` or any routed input made between enables has no effect on the pins until the next enable. At that enable the pins take the new selection.
- R8: The most negative sample has absolute value 2^(SAMPLE_W-1). It exceeds every threshold below that value, so a full-scale negative sample reads as the top magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample-clock enable; loads the pin register |
| smp_data | input | SAMPLE_W | Signed two's-complement sample |
| thr_lo | input | SAMPLE_W | Lowest magnitude threshold (unsigned) |
| thr_mid | input | SAMPLE_W | Middle threshold; also the 1-bit magnitude threshold |
| thr_hi | input | SAMPLE_W | Highest magnitude threshold (unsigned) |
| mag1_sel | input | 1 | 1 = sign plus 1-bit magnitude, 0 = sign plus 2-bit magnitude |
| test_sel | input | 2 | Pin routing select |
| fb_tick | input | 1 | Feedback divider terminal pulse |
| ref_tick | input | 1 | Reference divider terminal pulse |
| hs_flag | input | 1 | Handshake status flag |
| pump_up | input | 1 | Phase-detector up pulse |
| pump_dn | input | 1 | Phase-detector down pulse |
| sdo_bit | input | 1 | Serial data-out bit |
| diag_clk | input | 1 | Diagnostic clock level |
| cal_done | input | 1 | Filter calibration finished flag |
| clksel_flag | input | 1 | Clock-selected flag |
| pins | output | 3 | Registered output pins |

## Verification
The bench sweeps every 8-bit sample value in both magnitude formats under two threshold sets. One set is spread out and one has tied thresholds. Together they separate strict from non-strict comparisons, find sign and magnitude bits swapped between pins, and catch an absolute value that goes wrong on the most negative code. Each diagnostic selection is driven with all eight input combinations, so a crossed wire between two pins or between two selections produces a mismatch. Changes to the selection and inputs made between enables confirm that the pins hold until the next enable and then switch in one step.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int PIN_W   = 3;
  localparam int NUM_THR = 3;
  localparam int MID_IDX = 1;

  typedef enum logic [1:0] {
    TSEL_FLAGS  = 2'b00,
    TSEL_PUMP   = 2'b01,
    TSEL_COUNT  = 2'b10,
    TSEL_SAMPLE = 2'b11
  } tsel_e;
endpackage

// File: rtl/sfm_quantizer.sv
module sfm_quantizer #(
  parameter int W    = 8,
  parameter int NTHR = 3,
  localparam int LVL_W = $clog2(NTHR + 1)
) (
  input  logic [W-1:0]      sample,
  input  logic [NTHR*W-1:0] thr_flat,
  output logic              sign,
  output logic [NTHR-1:0]   above,
  output logic [LVL_W-1:0]  level
);
  logic [W-1:0] absval;

  assign sign   = sample[W-1];
  // Two's-complement negate; the most negative code maps to 2^(W-1) unsigned.
  assign absval = sign ? (~sample + W'(1)) : sample;

  for (genvar i = 0; i < NTHR; i++) begin : g_cmp
    assign above[i] = absval > thr_flat[i*W +: W];
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < NTHR; i++) level = level + LVL_W'(above[i]);
  end
endmodule

// File: rtl/sfm_pin_map.sv
module sfm_pin_map (
  input  logic       mag1_sel,
  input  logic       sign,
  input  logic       mag1,
  input  logic [1:0] mag2,
  output logic [2:0] smp_pins
);
  always_comb begin
    if (mag1_sel) smp_pins = {sign, mag1, 1'b0};
    else          smp_pins = {mag2[1], mag2[0], sign};
  end
endmodule

// File: rtl/sfm_diag_mux.sv
module sfm_diag_mux
  import sfm_pkg::*;
(
  input  tsel_e      sel,
  input  logic [2:0] smp_pins,
  input  logic [2:0] count_grp,
  input  logic [2:0] pump_grp,
  input  logic [2:0] flag_grp,
  output logic [2:0] pin_next
);
  always_comb begin
    unique case (sel)
      TSEL_SAMPLE: pin_next = smp_pins;
      TSEL_COUNT:  pin_next = count_grp;
      TSEL_PUMP:   pin_next = pump_grp;
      default:     pin_next = flag_grp;
    endcase
  end
endmodule

// File: rtl/sample_fmt_testmux.sv
module sample_fmt_testmux
  import sfm_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_en,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] thr_lo,
  input  logic [SAMPLE_W-1:0] thr_mid,
  input  logic [SAMPLE_W-1:0] thr_hi,
  input  logic                mag1_sel,
  input  logic [1:0]          test_sel,
  input  logic                fb_tick,
  input  logic                ref_tick,
  input  logic                hs_flag,
  input  logic                pump_up,
  input  logic                pump_dn,
  input  logic                sdo_bit,
  input  logic                diag_clk,
  input  logic                cal_done,
  input  logic                clksel_flag,
  output logic [2:0]          pins
);
  localparam int LVL_W = $clog2(NUM_THR + 1);

  logic                sign;
  logic [NUM_THR-1:0]  above;
  logic [LVL_W-1:0]    level;
  logic [2:0]          smp_pins;
  logic [2:0]          pin_next;
  logic [2:0]          pin_q;

  sfm_quantizer #(.W(SAMPLE_W), .NTHR(NUM_THR)) u_quant (
    .sample   (smp_data),
    .thr_flat ({thr_hi, thr_mid, thr_lo}),
    .sign     (sign),
    .above    (above),
    .level    (level)
  );

  sfm_pin_map u_map (
    .mag1_sel (mag1_sel),
    .sign     (sign),
    .mag1     (above[MID_IDX]),
    .mag2     (level[1:0]),
    .smp_pins (smp_pins)
  );

  sfm_diag_mux u_mux (
    .sel       (tsel_e'(test_sel)),
    .smp_pins  (smp_pins),
    .count_grp ({fb_tick, ref_tick, hs_flag}),
    .pump_grp  ({pump_up, pump_dn, sdo_bit}),
    .flag_grp  ({diag_clk, cal_done, clksel_flag}),
    .pin_next  (pin_next)
  );

  // One register for all pins: selection and data change together on the enable.
  always_ff @(posedge clk) begin
    if (rst)         pin_q <= '0;
    else if (smp_en) pin_q <= pin_next;
  end

  assign pins = pin_q;
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_en,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                mag1_sel,
  input logic [1:0]          test_sel,
  input logic                pump_up,
  input logic                pump_dn,
  input logic                sdo_bit,
  input logic [2:0]          pins
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> pins == 3'b000);

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(pins));

  a_r3_sign_pin0: assert property (@(posedge clk) disable iff (rst)
    (smp_en && test_sel == 2'b11 && !mag1_sel) |=> pins[0] == $past(smp_data[SAMPLE_W-1]));

  a_r5_pin0_low: assert property (@(posedge clk) disable iff (rst)
    (smp_en && test_sel == 2'b11 && mag1_sel) |=> pins[0] == 1'b0);

  a_r6_pump_route: assert property (@(posedge clk) disable iff (rst)
    (smp_en && test_sel == 2'b01) |=> pins == $past({pump_up, pump_dn, sdo_bit}));
endmodule

bind sample_fmt_testmux sfm_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .smp_data(smp_data),
  .mag1_sel(mag1_sel), .test_sel(test_sel), .pump_up(pump_up),
  .pump_dn(pump_dn), .sdo_bit(sdo_bit), .pins(pins)
);

// File: tb/sim_sample_fmt_testmux.sv
`timescale 1ns/1ps
module sim_sample_fmt_testmux;
  localparam int W = 8;

  logic clk = 0;
  logic rst = 1;
  logic smp_en = 0;
  logic [W-1:0] smp_data = '0, thr_lo = '0, thr_mid = '0, thr_hi = '0;
  logic mag1_sel = 0;
  logic [1:0] test_sel = 2'b11;
  logic fb_tick = 0, ref_tick = 0, hs_flag = 0, pump_up = 0, pump_dn = 0;
  logic sdo_bit = 0, diag_clk = 0, cal_done = 0, clksel_flag = 0;
  logic [2:0] pins;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sample_fmt_testmux #(.SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .smp_en(smp_en), .smp_data(smp_data),
    .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi),
    .mag1_sel(mag1_sel), .test_sel(test_sel),
    .fb_tick(fb_tick), .ref_tick(ref_tick), .hs_flag(hs_flag),
    .pump_up(pump_up), .pump_dn(pump_dn), .sdo_bit(sdo_bit),
    .diag_clk(diag_clk), .cal_done(cal_done), .clksel_flag(clksel_flag),
    .pins(pins)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pins=%b expected=%b", req, act, exp);
    end
  endtask

  // One enable pulse; pins are read at the following falling edge.
  task automatic strobe();
    smp_en = 1;
    @(negedge clk);
    smp_en = 0;
  endtask

  function automatic logic [2:0] model(input int v, input int tl, input int tm,
                                       input int th, input bit one);
    int a;
    int m;
    logic s;
    s = (v < 0);
    a = (v < 0) ? -v : v;
    m = (a > tl) + (a > tm) + (a > th);
    if (one) return {s, logic'(a > tm), 1'b0};
    return {logic'(m / 2), logic'(m % 2), s};
  endfunction

  task automatic sweep(input int tl, input int tm, input int th);
    thr_lo = W'(tl); thr_mid = W'(tm); thr_hi = W'(th);
    test_sel = 2'b11;
    for (int one = 0; one < 2; one++) begin
      mag1_sel = one[0];
      for (int v = -(1 << (W-1)); v < (1 << (W-1)); v++) begin
        smp_data = W'(v);
        strobe();
        if (v == -(1 << (W-1)))
          chk("R8 most negative", pins, model(v, tl, tm, th, one[0]));
        else if (one == 1)
          chk("R5 one-bit map", pins, model(v, tl, tm, th, 1'b1));
        else
          chk("R4/R3 two-bit map", pins, model(v, tl, tm, th, 1'b0));
      end
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset", pins, 3'b000);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", pins, 3'b000);

    // R3 R4 R5 R8: full sample sweeps under two threshold sets
    sweep(20, 60, 100);
    sweep(40, 40, 127);

    // R6: every routed input pattern in each diagnostic selection
    for (int s = 0; s < 3; s++) begin
      test_sel = 2'(s);
      for (int p = 0; p < 8; p++) begin
        {fb_tick, ref_tick, hs_flag}        = 3'(p);
        {pump_up, pump_dn, sdo_bit}         = 3'(p ^ 5);
        {diag_clk, cal_done, clksel_flag}   = 3'(p ^ 3);
        strobe();
        if (s == 2)      chk("R6 counter route", pins, 3'(p));
        else if (s == 1) chk("R6 pump route", pins, 3'(p ^ 5));
        else             chk("R6 flag route", pins, 3'(p ^ 3));
      end
    end

    // R7 R2: changes between enables are held off until the next enable
    thr_lo = 8'd20; thr_mid = 8'd60; thr_hi = 8'd100;
    test_sel = 2'b11; mag1_sel = 0; smp_data = 8'd110;
    strobe();
    chk("R7 baseline", pins, 3'b110);
    test_sel = 2'b10;
    {fb_tick, ref_tick, hs_flag} = 3'b001;
    smp_data = 8'h80;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R2 hold without enable", pins, 3'b110);
    end
    mag1_sel = 1;
    @(negedge clk);
    chk("R7 no early switch", pins, 3'b110);
    strobe();
    chk("R7 switch at enable", pins, 3'b001);
    test_sel = 2'b11;
    strobe();
    chk("R7 format change", pins, 3'b110);

    // R1: reset mid-run clears the pins
    rst = 1;
    @(negedge clk);
    chk("R1 reset mid-run", pins, 3'b000);
    rst = 0;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: pins=%b expected=done", pins);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule